// File: doc/BRIEF.md
# PLL Frequency Change Sequencer

This block moves a clock synthesizer to a new setting without disturbing the logic that runs from it. A request brings four codes: the reference divider, the post divider, the feedback multiplier and the loop bandwidth. Each divider or multiplier code is the wanted value minus one. The synthesizer output frequency is the reference frequency times the multiplier, divided by the reference divider and then by the post divider. The block keeps a copy of the codes that are currently programmed. It drives the synthesizer's control fields through a one-write-per-cycle register port. It also reads a lock status word and the current setting of the system clock selector.

When a change is needed and the system clock is taken from the synthesizer, the sequencer first moves the clock to the slow reference. It then holds the synthesizer in reset, loads the new codes, releases reset and waits a settle time that depends on the reference divider. After that it polls for lock, with a limit on how long it waits. If lock does not arrive in time, the sequencer programs the previous codes again through the same steps and flags an error. That second attempt is never retried. Last, the clock selector is moved back to the synthesizer, but only if the sequencer moved it away.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `wr_en` are low and the programmed codes equal the INIT parameters.
- R2: A request whose four codes equal the programmed codes makes `done` high in the cycle after acceptance, with `err` low and no write.
- R3: `mux_mode_i` values are 0 slow, 1 synthesizer and 2 deep slow. Only when it reads 1 at acceptance does the sequencer write the mode target (`wr_sel`=0) with 0 first and with 1 as its last write. Otherwise it writes no mode value.
- R4: Programming writes come in the order control (`wr_sel`=4, data bit0=1, reset on), divider (`wr_sel`=1, reference code in bits 5:0, post code in bits 11:8), multiplier (`wr_sel`=2, code in bits 12:0), bandwidth (`wr_sel`=3, code in bits 11:0), control with data 0. All other data bits are 0, and there is one write per cycle.
- R5: After the reset-release write, the sequencer ignores lock for ((nr_code+1)*500/24+1)*CYC_PER_US cycles and then polls once per cycle.
- R6: Lock is bit LOCK_BIT of `lock_i`. When it is seen high, the sequence finishes: `done` rises two cycles after that poll if the clock was parked, and one cycle after if it was not.
- R7: If lock is not seen within LOCK_TIMEOUT polling cycles, the previous codes are programmed again in the R4 order. No extra park is written, and `err` is high with `done`.
- R8: If the restore attempt also times out, no third attempt is made. The mux is restored as in R3, `done` rises with `err` high, and the block returns to idle holding the restored codes.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle, and `done` lasts one cycle. Requests that arrive while `busy` is high have no effect on the writes or on the state that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Change request, taken when idle |
| req_nr | input | NR_W | Reference divider code (value minus one) |
| req_od | input | OD_W | Post divider code (value minus one) |
| req_nf | input | NF_W | Feedback multiplier code (value minus one) |
| req_bw | input | BW_W | Loop bandwidth code |
| mux_mode_i | input | 2 | Current system clock selector value |
| lock_i | input | LOCK_W | Status word holding the lock bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Lock failure, valid with done |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 3 | Write target: 0 mode, 1 divider, 2 multiplier, 3 bandwidth, 4 control |
| wr_data | output | DATA_W | Write data |

## Verification
The bench runs the change request with the selector set to synthesizer, slow and deep slow. Comparing these separates the park and unpark path from the plain path. It pairs each case with a lock model that locks on the first attempt, on the restore attempt only, or never. These three cases separate the normal finish, the rollback and the give-up path, each by its write list, its error flag and its final codes. It measures the gap from reset release to done for divider codes from 0 to 63, which exposes any error in the settle formula or in the polling window. Repeating the current codes, and firing requests in the middle of a sequence, show that the no-write shortcut works and that requests while busy are dropped.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PARK,
        ST_RST_ON,
        ST_WR_DIV,
        ST_WR_MUL,
        ST_WR_BW,
        ST_RST_OFF,
        ST_SETTLE,
        ST_POLL,
        ST_UNPARK,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        WS_MODE = 3'd0,
        WS_DIV  = 3'd1,
        WS_MUL  = 3'd2,
        WS_BW   = 3'd3,
        WS_CTRL = 3'd4
    } wsel_e;

    localparam logic [1:0] MODE_SLOW = 2'd0;
    localparam logic [1:0] MODE_PLL  = 2'd1;
    localparam logic [1:0] MODE_DEEP = 2'd2;

endpackage

// File: rtl/pll_seq_settle.sv
// Settle time after reset release, in clock cycles, for a reference divider code.
module pll_seq_settle #(
    parameter int NR_W       = 6,
    parameter int CYC_PER_US = 24,
    parameter int TMR_W      = 16
) (
    input  logic [NR_W-1:0]  nr_code,
    output logic [TMR_W-1:0] cycles
);
    int unsigned nr_val;
    int unsigned us_val;
    int unsigned cyc_val;

    always_comb begin
        nr_val  = 32'(nr_code) + 32'd1;
        us_val  = (nr_val * 32'd500) / 32'd24 + 32'd1;
        cyc_val = us_val * 32'(CYC_PER_US);
        cycles  = TMR_W'(cyc_val);
    end
endmodule

// File: rtl/pll_seq_wrfmt.sv
// Builds the register write for the current sequencer step.
module pll_seq_wrfmt
    import pll_seq_pkg::*;
#(
    parameter int NR_W   = 6,
    parameter int OD_W   = 4,
    parameter int NF_W   = 13,
    parameter int BW_W   = 12,
    parameter int DATA_W = 16,
    parameter int OD_POS = 8
) (
    input  seq_state_e        st,
    input  logic [NR_W-1:0]   nr,
    input  logic [OD_W-1:0]   od,
    input  logic [NF_W-1:0]   nf,
    input  logic [BW_W-1:0]   bw,
    output logic              wr_en,
    output logic [2:0]        wr_sel,
    output logic [DATA_W-1:0] wr_data
);
    always_comb begin
        wr_en   = 1'b1;
        wr_sel  = WS_CTRL;
        wr_data = '0;
        case (st)
            ST_PARK: begin
                wr_sel       = WS_MODE;
                wr_data[1:0] = MODE_SLOW;
            end
            ST_RST_ON: begin
                wr_sel     = WS_CTRL;
                wr_data[0] = 1'b1;
            end
            ST_WR_DIV: begin
                wr_sel                    = WS_DIV;
                wr_data[NR_W-1:0]         = nr;
                wr_data[OD_POS +: OD_W]   = od;
            end
            ST_WR_MUL: begin
                wr_sel            = WS_MUL;
                wr_data[NF_W-1:0] = nf;
            end
            ST_WR_BW: begin
                wr_sel            = WS_BW;
                wr_data[BW_W-1:0] = bw;
            end
            ST_RST_OFF: begin
                wr_sel = WS_CTRL;
            end
            ST_UNPARK: begin
                wr_sel       = WS_MODE;
                wr_data[1:0] = MODE_PLL;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int NR_W         = 6,
    parameter int OD_W         = 4,
    parameter int NF_W         = 13,
    parameter int BW_W         = 12,
    parameter int DATA_W       = 16,
    parameter int OD_POS       = 8,
    parameter int LOCK_W       = 8,
    parameter int LOCK_BIT     = 0,
    parameter int CYC_PER_US   = 24,
    parameter int LOCK_TIMEOUT = 24000,
    parameter logic [NR_W-1:0] INIT_NR = '0,
    parameter logic [OD_W-1:0] INIT_OD = '0,
    parameter logic [NF_W-1:0] INIT_NF = '0,
    parameter logic [BW_W-1:0] INIT_BW = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NR_W-1:0]   req_nr,
    input  logic [OD_W-1:0]   req_od,
    input  logic [NF_W-1:0]   req_nf,
    input  logic [BW_W-1:0]   req_bw,
    input  logic [1:0]        mux_mode_i,
    input  logic [LOCK_W-1:0] lock_i,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              wr_en,
    output logic [2:0]        wr_sel,
    output logic [DATA_W-1:0] wr_data
);
    // Longest settle: largest reference divider, in cycles.
    localparam int MAX_US   = (((1 << NR_W) * 500) / 24) + 1;
    localparam int MAX_CYC  = MAX_US * CYC_PER_US;
    localparam int TMR_MAX  = (MAX_CYC > LOCK_TIMEOUT) ? MAX_CYC : LOCK_TIMEOUT;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] POLL_LAST = TMR_W'(LOCK_TIMEOUT - 1);

    typedef struct packed {
        logic [NR_W-1:0] nr;
        logic [OD_W-1:0] od;
        logic [NF_W-1:0] nf;
        logic [BW_W-1:0] bw;
    } cfg_t;

    typedef struct packed {
        seq_state_e       st;
        cfg_t             tgt;     // codes being programmed
        cfg_t             cur;     // codes now in the synthesizer
        cfg_t             prev;    // codes to fall back to
        logic             parked;
        logic             retry;
        logic             err;
        logic [TMR_W-1:0] tmr;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    cfg_t req_cfg;
    logic [TMR_W-1:0] settle_cyc;
    logic lock_seen;
    logic unused_lock;

    assign req_cfg     = '{nr: req_nr, od: req_od, nf: req_nf, bw: req_bw};
    assign lock_seen   = lock_i[LOCK_BIT];
    assign unused_lock = ^lock_i;

    pll_seq_settle #(
        .NR_W       (NR_W),
        .CYC_PER_US (CYC_PER_US),
        .TMR_W      (TMR_W)
    ) u_settle (
        .nr_code (ctx_q.tgt.nr),
        .cycles  (settle_cyc)
    );

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.err   = 1'b0;
                    ctx_d.retry = 1'b0;
                    if (req_cfg == ctx_q.cur) begin
                        ctx_d.st = ST_DONE;
                    end else begin
                        ctx_d.tgt    = req_cfg;
                        ctx_d.prev   = ctx_q.cur;
                        ctx_d.parked = (mux_mode_i == MODE_PLL);
                        ctx_d.st     = (mux_mode_i == MODE_PLL) ? ST_PARK : ST_RST_ON;
                    end
                end
            end
            ST_PARK:   ctx_d.st = ST_RST_ON;
            ST_RST_ON: ctx_d.st = ST_WR_DIV;
            ST_WR_DIV: ctx_d.st = ST_WR_MUL;
            ST_WR_MUL: ctx_d.st = ST_WR_BW;
            ST_WR_BW:  ctx_d.st = ST_RST_OFF;
            ST_RST_OFF: begin
                ctx_d.cur = ctx_q.tgt;
                ctx_d.tmr = settle_cyc - TMR_W'(1);
                ctx_d.st  = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (ctx_q.tmr == '0) begin
                    ctx_d.st = ST_POLL;
                end else begin
                    ctx_d.tmr = ctx_q.tmr - TMR_W'(1);
                end
            end
            ST_POLL: begin
                if (lock_seen) begin
                    ctx_d.st = ctx_q.parked ? ST_UNPARK : ST_DONE;
                end else if (ctx_q.tmr == POLL_LAST) begin
                    ctx_d.err = 1'b1;
                    if (!ctx_q.retry) begin
                        ctx_d.retry = 1'b1;
                        ctx_d.tgt   = ctx_q.prev;
                        ctx_d.st    = ST_RST_ON;
                    end else begin
                        ctx_d.st = ctx_q.parked ? ST_UNPARK : ST_DONE;
                    end
                end else begin
                    ctx_d.tmr = ctx_q.tmr + TMR_W'(1);
                end
            end
            ST_UNPARK: ctx_d.st = ST_DONE;
            ST_DONE:   ctx_d.st = ST_IDLE;
            default:   ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q        <= '0;
            ctx_q.st     <= ST_IDLE;
            ctx_q.cur.nr <= INIT_NR;
            ctx_q.cur.od <= INIT_OD;
            ctx_q.cur.nf <= INIT_NF;
            ctx_q.cur.bw <= INIT_BW;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    pll_seq_wrfmt #(
        .NR_W   (NR_W),
        .OD_W   (OD_W),
        .NF_W   (NF_W),
        .BW_W   (BW_W),
        .DATA_W (DATA_W),
        .OD_POS (OD_POS)
    ) u_wrfmt (
        .st      (ctx_q.st),
        .nr      (ctx_q.tgt.nr),
        .od      (ctx_q.tgt.od),
        .nf      (ctx_q.tgt.nf),
        .bw      (ctx_q.tgt.bw),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data)
    );

    assign busy = (ctx_q.st != ST_IDLE);
    assign done = (ctx_q.st == ST_DONE);
    assign err  = ctx_q.err & done;
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk
    import pll_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [1:0] low_bits
);
    logic held_q;
    logic parked_q;

    // Mirror of the reset level and the selector as seen through the write port.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q   <= 1'b0;
            parked_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel == WS_CTRL) held_q <= low_bits[0];
            if (wr_sel == WS_MODE) parked_q <= (low_bits == MODE_SLOW);
        end
    end

    assert_fields_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == WS_DIV || wr_sel == WS_MUL || wr_sel == WS_BW)) |-> held_q);

    assert_released_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !held_q);

    assert_unpark_needs_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WS_MODE && low_bits == MODE_PLL) |-> parked_q);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_write_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
endmodule

bind pll_reprog_seq pll_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .low_bits (wr_data[1:0])
);

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_US     = 1;
    localparam int TMO        = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_nr = '0;
    logic [3:0]  req_od = '0;
    logic [12:0] req_nf = '0;
    logic [11:0] req_bw = '0;
    logic [1:0]  mode_reg = 2'd1;
    logic        lock_r = 1'b1;
    logic [7:0]  lock_i;
    logic        busy, done, err, wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;

    assign lock_i = {7'b0, lock_r};

    pll_reprog_seq #(
        .CYC_PER_US   (CYC_US),
        .LOCK_TIMEOUT (TMO)
    ) i_pll_reprog_seq (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_nr (req_nr), .req_od (req_od), .req_nf (req_nf), .req_bw (req_bw),
        .mux_mode_i (mode_reg), .lock_i (lock_i),
        .busy (busy), .done (done), .err (err),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_run = 0;
    int n_fail = 0;

    // Bench model of the programmed codes
    logic [5:0]  m_nr = '0;
    logic [3:0]  m_od = '0;
    logic [12:0] m_nf = '0;
    logic [11:0] m_bw = '0;

    // Write log and synthesizer/lock model
    logic [2:0]  log_sel [16];
    logic [15:0] log_dat [16];
    int          log_n = 0;
    logic [2:0]  exp_sel [16];
    logic [15:0] exp_dat [16];
    int          exp_n = 0;
    int          attempt = 0;
    int          fail_cnt = 0;
    int          t_rel = 0;

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (log_n < 16) begin
                log_sel[log_n] = wr_sel;
                log_dat[log_n] = wr_data;
            end
            log_n = log_n + 1;
            if (wr_sel == 3'd0) mode_reg = wr_data[1:0];
            if (wr_sel == 3'd4) begin
                if (wr_data[0]) begin
                    lock_r  = 1'b0;
                    attempt = attempt + 1;
                end else begin
                    t_rel  = cyc;
                    lock_r = (attempt > fail_cnt);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(input logic [2:0] s, input logic [15:0] d);
        exp_sel[exp_n] = s;
        exp_dat[exp_n] = d;
        exp_n++;
    endtask

    task automatic prog(input logic [5:0] nr, input logic [3:0] od,
                        input logic [12:0] nf, input logic [11:0] bw);
        push(3'd4, 16'd1);
        push(3'd1, {4'b0, od, 2'b0, nr});
        push(3'd2, {3'b0, nf});
        push(3'd3, {4'b0, bw});
        push(3'd4, 16'd0);
    endtask

    function automatic int settle_of(input logic [5:0] nr);
        return (((int'(nr) + 1) * 500) / 24 + 1) * CYC_US;
    endfunction

    task automatic run_req(input logic [5:0] nr, input logic [3:0] od,
                           input logic [12:0] nf, input logic [11:0] bw,
                           input logic [1:0] mode, input int fails,
                           input bit spam, input string tag);
        bit match;
        bit parked;
        int waited;
        int t_done;
        int bad;
        int gap;
        logic [5:0] last_nr;
        match  = (nr == m_nr) && (od == m_od) && (nf == m_nf) && (bw == m_bw);
        parked = (mode == 2'd1);
        @(negedge clk);
        mode_reg = mode; log_n = 0; attempt = 0; fail_cnt = fails;
        req_nr = nr; req_od = od; req_nf = nf; req_bw = bw; req_valid = 1'b1;
        waited = 0;
        t_done = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            waited++;
            if (waited == 1) chk(busy == 1'b1, {"R9 busy after accept ", tag}, busy, 1);
            if (done) begin
                t_done = cyc;
            end else if (spam && (waited % 3 == 0)) begin
                req_valid = 1'b1;
                req_nr = ~nr; req_nf = ~nf;
            end
        end while (!done && waited < 5000);
        req_valid = 1'b0;
        chk(done == 1'b1, {"R9 done seen ", tag}, done, 1);
        exp_n = 0;
        if (match) begin
            chk(waited == 1, {"R2 match latency ", tag}, waited, 1);
            chk(log_n == 0, {"R2 no writes ", tag}, log_n, 0);
            chk(err == 1'b0, {"R2 err low ", tag}, err, 0);
        end else begin
            if (parked) push(3'd0, 16'd0);
            prog(nr, od, nf, bw);
            if (fails >= 1) prog(m_nr, m_od, m_nf, m_bw);
            if (parked) push(3'd0, 16'd1);
            chk(log_n == exp_n, {"R4 R7 write count ", tag}, log_n, exp_n);
            bad = -1;
            for (int i = 0; i < exp_n && i < log_n; i++)
                if (bad < 0 && (log_sel[i] != exp_sel[i] || log_dat[i] != exp_dat[i])) bad = i;
            if (bad >= 0)
                chk(1'b0, {"R3 R4 write order ", tag}, {log_sel[bad], log_dat[bad]},
                    {exp_sel[bad], exp_dat[bad]});
            else
                chk(1'b1, "R4", 0, 0);
            chk(err == (fails >= 1), {"R7 R8 err flag ", tag}, err, fails >= 1);
            chk(mode_reg == mode, {"R3 selector restored ", tag}, mode_reg, mode);
            last_nr = (fails >= 1) ? m_nr : nr;
            gap = settle_of(last_nr) + 2 + int'(parked);
            if (fails >= 2) gap = settle_of(last_nr) + TMO + 1 + int'(parked);
            chk(t_done - t_rel == gap, {(fails >= 2) ? "R8 R6" : "R5 R6", " timing ", tag},
                t_done - t_rel, gap);
            if (fails == 0) begin
                m_nr = nr; m_od = od; m_nf = nf; m_bw = bw;
            end
        end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && log_n == exp_n, {"R9 idle after done ", tag}, log_n, exp_n);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !wr_en, "R1 reset outputs", {busy, done, err, wr_en}, 0);
        // R1/R2: reset codes are all zero, so a zero request is a match
        run_req(6'd0, 4'd0, 13'd0, 12'd0, 2'd1, 0, 1'b0, "init match");
        run_req(6'd0, 4'd1, 13'd49, 12'd24, 2'd1, 0, 1'b0, "parked nr0");
        run_req(6'd0, 4'd1, 13'd49, 12'd24, 2'd0, 0, 1'b0, "repeat match");
        run_req(6'd3, 4'd0, 13'd99, 12'd7, 2'd0, 0, 1'b0, "slow mux");
        run_req(6'd5, 4'd2, 13'd8, 12'd3, 2'd2, 0, 1'b0, "deep mux");
        run_req(6'd7, 4'd3, 13'd300, 12'd11, 2'd1, 1, 1'b0, "rollback R7");
        run_req(6'd2, 4'd2, 13'd77, 12'd5, 2'd1, 2, 1'b0, "give up R8");
        run_req(6'd2, 4'd2, 13'd77, 12'd5, 2'd0, 2, 1'b0, "give up unparked R8");
        run_req(6'd9, 4'd1, 13'd123, 12'd9, 2'd1, 0, 1'b1, "busy spam R9");
        run_req(6'd63, 4'd15, 13'd8191, 12'd4095, 2'd1, 0, 1'b0, "max nr R5");
        for (int k = 0; k < 20; k++) begin
            logic [5:0]  rnr;
            logic [3:0]  rod;
            logic [12:0] rnf;
            logic [11:0] rbw;
            logic [1:0]  rmode;
            int rf;
            rnr   = 6'($urandom_range(0, 15));
            rod   = 4'($urandom);
            rnf   = 13'($urandom);
            rbw   = 12'($urandom);
            rmode = 2'($urandom_range(0, 2));
            rf    = $urandom_range(0, 2);
            run_req(rnr, rod, rnf, rbw, rmode, rf, k[2], "random");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule